// File: doc/BRIEF.md
# Auxiliary TAP Port Sharing Controller

This block sits beside a primary JTAG TAP controller and lets it lend the test pins to one of up to fifteen downstream TAP controllers. When the primary controller passes through Update-IR with an instruction code that names an auxiliary TAP present on the device, the block hands the port to that TAP. From then on the pin TMS and TDI are forwarded to that TAP, and its TDO is driven onto the pin TDO.

The primary controller keeps following the pin TMS sequence while the port is lent, and reports its state to this block. The port comes back to the primary controller at Update-DR, but only if the scan that ends there went through Pause-DR. Test-Logic-Reset or the asynchronous test reset also takes the port back. Every auxiliary TAP that does not own the port sees TMS held at 0, so it stays parked in Run-Test/Idle.

All selection state changes on the falling edge of TCK, so the forwarded TMS is stable well before the rising edge that the auxiliary TAP samples. The block runs only on TCK. Any exchange with system-clock logic needs synchronisers outside the block.

Top module: `auxtap_share`

## Requirements
- R1: While trstN is low, auxOwn is 0, every auxTms and auxTdi bit is 0, and tdoPin equals primaryTdo.
- R2: At a falling TCK edge where primaryState is Update-IR (4'hD), irUpdate is 1 and irCode equals AUX_BASE+k for a present TAP k (k < N_AUX, AUX_PRESENT[k]=1), TAP k takes the port and auxOwn becomes 1.
- R3: While TAP k owns the port, auxTms[k] follows tms, auxTdi[k] follows tdi, and tdoPin follows auxTdo[k].
- R4: Every auxiliary channel that does not own the port has auxTms and auxTdi at 0. At most one auxTms bit is ever 1.
- R5: An irCode naming an absent TAP (AUX_PRESENT bit 0), or one outside AUX_BASE..AUX_BASE+N_AUX-1, selects nothing. The port then stays with the primary controller and tdoPin equals primaryTdo.
- R6: While the port is lent, a falling edge in Update-DR (4'h5) returns it to the primary controller if a falling edge in Pause-DR (4'h3) came after the most recent falling edge in Capture-DR (4'h6).
- R7: Update-DR with no Pause-DR since the last Capture-DR leaves the auxiliary TAP in control.
- R8: While the port is lent, irUpdate has no effect, so the selected TAP does not change.
- R9: A falling edge in Test-Logic-Reset (4'hF) returns the port to the primary controller and forgets any Pause-DR seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Pin test mode select |
| tdi | input | 1 | Pin test data in |
| tdoPin | output | 1 | Data driven to the TDO pin |
| primaryTdo | input | 1 | Serial output of the primary controller |
| primaryState | input | 4 | Current state of the primary TAP |
| irUpdate | input | 1 | Strobe: primary instruction register updates |
| irCode | input | IR_W | Instruction code being updated |
| auxTms | output | N_AUX | TMS to each auxiliary TAP |
| auxTdi | output | N_AUX | TDI to each auxiliary TAP |
| auxTdo | input | N_AUX | TDO from each auxiliary TAP |
| auxOwn | output | 1 | An auxiliary TAP owns the port |

## Verification
The bench runs its own TAP state machine from the TMS it drives, and compares every output on every cycle against a behavioural model. It targets DR scans that end with and without Pause-DR, scans that pause and then return to Shift-DR, and IR updates issued while the port is lent. It also covers codes for an absent TAP and codes past the last index, a walk into Test-Logic-Reset, and trstN pulled low while the port is lent. A design that ignored the pause condition would release on the first DR scan or never release at all. One that honoured irUpdate during a loan would jump to a different TAP. One that decoded presence wrongly would hand the port to a TAP that does not exist.

// File: rtl/auxtap_pkg.sv
package auxtap_pkg;

  localparam int AUX_MAX = 15;
  localparam int IDX_W = $clog2(AUX_MAX + 1);

  typedef enum logic [3:0] {
    TAP_EX2_DR   = 4'h0,
    TAP_EX1_DR   = 4'h1,
    TAP_SH_DR    = 4'h2,
    TAP_PAUSE_DR = 4'h3,
    TAP_SEL_IR   = 4'h4,
    TAP_UPD_DR   = 4'h5,
    TAP_CAP_DR   = 4'h6,
    TAP_SEL_DR   = 4'h7,
    TAP_EX2_IR   = 4'h8,
    TAP_EX1_IR   = 4'h9,
    TAP_SH_IR    = 4'hA,
    TAP_PAUSE_IR = 4'hB,
    TAP_RTI      = 4'hC,
    TAP_UPD_IR   = 4'hD,
    TAP_CAP_IR   = 4'hE,
    TAP_TLR      = 4'hF
  } tapState_e;

  // Strobes from control to routing, valid for one falling edge.
  typedef struct packed {
    logic             take;
    logic             drop;
    logic [IDX_W-1:0] idx;
  } handoff_t;

endpackage

// File: rtl/auxtap_ctrl.sv
module auxtap_ctrl
  import auxtap_pkg::*;
#(
  parameter int N_AUX = 15,
  parameter int IR_W = 5,
  parameter int AUX_BASE = 16,
  parameter logic [N_AUX-1:0] AUX_PRESENT = '1
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic [3:0]      primaryState,
  input  logic            irUpdate,
  input  logic [IR_W-1:0] irCode,
  input  logic            ownedQ,
  output handoff_t        hand
);

  localparam int LAST_CODE = AUX_BASE + N_AUX - 1;

  tapState_e         curState;
  logic              pauseSeen;
  logic              codeHit;
  logic [IDX_W-1:0]  hitIdx;
  logic              inRange;
  logic [IR_W-1:0]   offs;

  assign curState = tapState_e'(primaryState);
  assign inRange  = (int'(irCode) >= AUX_BASE) && (int'(irCode) <= LAST_CODE);
  assign offs     = irCode - IR_W'(AUX_BASE);

  // Decode an access code into a present auxiliary index.
  always_comb begin
    codeHit = 1'b0;
    hitIdx  = '0;
    for (int i = 0; i < N_AUX; i++) begin
      if (inRange && offs == IR_W'(i) && AUX_PRESENT[i]) begin
        codeHit = 1'b1;
        hitIdx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    hand.take = !ownedQ && irUpdate && (curState == TAP_UPD_IR) && codeHit;
    hand.idx  = hitIdx;
    hand.drop = ownedQ && ((curState == TAP_TLR) ||
                           (curState == TAP_UPD_DR && pauseSeen));
  end

  // Pause-DR tracking for the scan in progress.
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      pauseSeen <= 1'b0;
    end else if (!ownedQ || hand.drop || curState == TAP_CAP_DR) begin
      pauseSeen <= 1'b0;
    end else if (curState == TAP_PAUSE_DR) begin
      pauseSeen <= 1'b1;
    end
  end

  // R2: a take strobe must carry an index of an existing channel
  a_r2_take_index_valid: assert property (@(negedge tck) disable iff (!trstN)
    hand.take |-> (int'(hand.idx) < N_AUX) && AUX_PRESENT[hand.idx]);

endmodule

// File: rtl/auxtap_route.sv
module auxtap_route
  import auxtap_pkg::*;
#(
  parameter int N_AUX = 15
) (
  input  logic             tck,
  input  logic             trstN,
  input  handoff_t         hand,
  input  logic [3:0]       primaryState,
  input  logic             irUpdate,
  input  logic             tms,
  input  logic             tdi,
  input  logic             primaryTdo,
  input  logic [N_AUX-1:0] auxTdo,
  output logic [N_AUX-1:0] auxTms,
  output logic [N_AUX-1:0] auxTdi,
  output logic             tdoPin,
  output logic             ownedQ
);

  logic [IDX_W-1:0] selQ;

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      ownedQ <= 1'b0;
      selQ   <= '0;
    end else if (hand.drop) begin
      ownedQ <= 1'b0;
    end else if (hand.take) begin
      ownedQ <= 1'b1;
      selQ   <= hand.idx;
    end
  end

  for (genvar g = 0; g < N_AUX; g++) begin : gChan
    logic chanOn;
    assign chanOn    = ownedQ && (selQ == IDX_W'(g));
    assign auxTms[g] = chanOn & tms;
    assign auxTdi[g] = chanOn & tdi;
  end

  always_comb begin
    tdoPin = primaryTdo;
    for (int i = 0; i < N_AUX; i++) begin
      if (ownedQ && selQ == IDX_W'(i)) tdoPin = auxTdo[i];
    end
  end

  // R4: never more than one auxiliary TMS active
  a_r4_single_tms: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0(auxTms));

  // R2: the port is only taken after an Update-IR with the strobe
  a_r2_take_after_upd_ir: assert property (@(negedge tck) disable iff (!trstN)
    $rose(ownedQ) |-> ($past(primaryState) == TAP_UPD_IR) && $past(irUpdate));

  // R6, R9: the port only returns in Update-DR or Test-Logic-Reset
  a_r6_drop_state: assert property (@(negedge tck) disable iff (!trstN)
    $fell(ownedQ) |-> ($past(primaryState) == TAP_UPD_DR) ||
                      ($past(primaryState) == TAP_TLR));

  // R8: selection holds during a loan
  a_r8_sel_held: assert property (@(negedge tck) disable iff (!trstN)
    (ownedQ && $past(ownedQ)) |-> $stable(selQ));

endmodule

// File: rtl/auxtap_share.sv
module auxtap_share
  import auxtap_pkg::*;
#(
  parameter int N_AUX = 15,
  parameter int IR_W = 5,
  parameter int AUX_BASE = 16,
  parameter logic [N_AUX-1:0] AUX_PRESENT = '1
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdoPin,
  input  logic             primaryTdo,
  input  logic [3:0]       primaryState,
  input  logic             irUpdate,
  input  logic [IR_W-1:0]  irCode,
  output logic [N_AUX-1:0] auxTms,
  output logic [N_AUX-1:0] auxTdi,
  input  logic [N_AUX-1:0] auxTdo,
  output logic             auxOwn
);

  handoff_t hand;
  logic     ownedQ;

  auxtap_ctrl #(
    .N_AUX(N_AUX), .IR_W(IR_W), .AUX_BASE(AUX_BASE), .AUX_PRESENT(AUX_PRESENT)
  ) uCtrl (
    .tck(tck), .trstN(trstN), .primaryState(primaryState),
    .irUpdate(irUpdate), .irCode(irCode), .ownedQ(ownedQ), .hand(hand)
  );

  auxtap_route #(.N_AUX(N_AUX)) uRoute (
    .tck(tck), .trstN(trstN), .hand(hand), .primaryState(primaryState),
    .irUpdate(irUpdate), .tms(tms), .tdi(tdi), .primaryTdo(primaryTdo),
    .auxTdo(auxTdo), .auxTms(auxTms), .auxTdi(auxTdi), .tdoPin(tdoPin),
    .ownedQ(ownedQ)
  );

  assign auxOwn = ownedQ;

endmodule

// File: tb/tb_auxtap_share.sv
module tb_auxtap_share;

  localparam int N = 15;
  localparam int IRW = 5;
  localparam int BASE = 16;
  localparam logic [N-1:0] PRESENT = 15'h5FFF; // TAP 13 absent

  logic tck = 0, trstN = 0, tms = 1, tdi = 0, primaryTdo = 0, irUpdate = 0;
  logic [3:0] primaryState = 4'hF;
  logic [IRW-1:0] irCode = '0;
  logic [N-1:0] auxTdo = '0;
  logic [N-1:0] auxTms, auxTdi;
  logic tdoPin, auxOwn;

  int checks = 0, errors = 0;
  string curReq = "R1";
  logic [3:0] tapState = 4'hF;
  bit mOwned = 0, mPause = 0;
  int mSel = 0;

  always #5 tck = ~tck;

  auxtap_share #(.N_AUX(N), .IR_W(IRW), .AUX_BASE(BASE), .AUX_PRESENT(PRESENT)) dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdoPin(tdoPin),
    .primaryTdo(primaryTdo), .primaryState(primaryState), .irUpdate(irUpdate),
    .irCode(irCode), .auxTms(auxTms), .auxTdi(auxTdi), .auxTdo(auxTdo),
    .auxOwn(auxOwn)
  );

  function automatic logic [3:0] tapNext(logic [3:0] s, logic m);
    case (s)
      4'hF: return m ? 4'hF : 4'hC;
      4'hC: return m ? 4'h7 : 4'hC;
      4'h7: return m ? 4'h4 : 4'h6;
      4'h6: return m ? 4'h1 : 4'h2;
      4'h2: return m ? 4'h1 : 4'h2;
      4'h1: return m ? 4'h5 : 4'h3;
      4'h3: return m ? 4'h0 : 4'h3;
      4'h0: return m ? 4'h5 : 4'h2;
      4'h5: return m ? 4'h7 : 4'hC;
      4'h4: return m ? 4'hF : 4'hE;
      4'hE: return m ? 4'h9 : 4'hA;
      4'hA: return m ? 4'h9 : 4'hA;
      4'h9: return m ? 4'hD : 4'hB;
      4'hB: return m ? 4'h8 : 4'hB;
      4'h8: return m ? 4'hD : 4'hA;
      default: return m ? 4'h7 : 4'hC;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    int k;
    if (!trstN) begin
      mOwned = 0; mPause = 0;
    end else if (mOwned) begin
      if (tapState == 4'hF || (tapState == 4'h5 && mPause)) begin
        mOwned = 0; mPause = 0;
      end else if (tapState == 4'h6) mPause = 0;
      else if (tapState == 4'h3) mPause = 1;
    end else if (tapState == 4'hD && irUpdate) begin
      k = int'(irCode) - BASE;
      if (k >= 0 && k < N && PRESENT[k]) begin
        mOwned = 1; mSel = k; mPause = 0;
      end
    end
  endtask

  task automatic compareAll();
    chk(curReq, "auxOwn", int'(auxOwn), int'(mOwned));
    chk(mOwned ? "R3" : curReq, "tdoPin", int'(tdoPin),
        int'(mOwned ? auxTdo[mSel] : primaryTdo));
    for (int i = 0; i < N; i++) begin
      bit on = mOwned && (mSel == i);
      chk(on ? "R3" : "R4", $sformatf("auxTms[%0d]", i), int'(auxTms[i]), int'(on & tms));
      chk(on ? "R3" : "R4", $sformatf("auxTdi[%0d]", i), int'(auxTdi[i]), int'(on & tdi));
    end
  endtask

  // Entered just after a rising edge; leaves just after the next one.
  task automatic tick(input logic tmsV);
    tms = tmsV; tdi = 1'($urandom); primaryTdo = 1'($urandom); auxTdo = N'($urandom);
    @(negedge tck);
    modelEdge();
    #2 compareAll();
    @(posedge tck); #1;
    tapState = !trstN ? 4'hF : tapNext(tapState, tms);
    primaryState = tapState;
    irUpdate = (tapState == 4'hD);
  endtask

  task automatic toIdle();
    for (int i = 0; i < 5; i++) tick(1);
    tick(0);
  endtask

  task automatic irScan(input int code);
    irCode = IRW'(code);
    tick(1); tick(1); tick(0); tick(0);
    for (int i = 0; i < IRW - 1; i++) tick(0);
    tick(1); tick(1); tick(0); tick(0);
  endtask

  task automatic drScan(input bit withPause, input bit reshift);
    tick(1); tick(0); tick(0);
    for (int i = 0; i < 4; i++) tick(0);
    tick(1);
    if (withPause) begin
      tick(0); tick(0); tick(1);
      if (reshift) begin tick(0); tick(0); tick(1); end
    end
    tick(1); tick(0); tick(0);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(posedge tck); #1;
    curReq = "R1";
    for (int i = 0; i < 4; i++) tick(1);
    trstN = 1;
    toIdle();
    curReq = "R2"; irScan(BASE + 3);
    chk("R2", "auxOwn after select 3", int'(auxOwn), 1);
    curReq = "R7"; drScan(0, 0);
    chk("R7", "auxOwn after scan without pause", int'(auxOwn), 1);
    curReq = "R6"; drScan(1, 1);
    chk("R6", "auxOwn after paused scan", int'(auxOwn), 0);
    curReq = "R5"; irScan(BASE + 13);
    chk("R5", "auxOwn absent TAP", int'(auxOwn), 0);
    irScan(31); irScan(3);
    chk("R5", "auxOwn out of range", int'(auxOwn), 0);
    curReq = "R2"; irScan(BASE + 0);
    curReq = "R8"; irScan(BASE + 5);
    chk("R8", "auxTms[5] after ignored update", int'(auxTms[5]), 0);
    curReq = "R6"; drScan(1, 0);
    curReq = "R2"; irScan(BASE + 14);
    curReq = "R9"; toIdle();
    chk("R9", "auxOwn after reset walk", int'(auxOwn), 0);
    curReq = "R2"; irScan(BASE + 7);
    curReq = "R1"; trstN = 0; tick(1); tick(1); trstN = 1;
    chk("R1", "auxOwn after trst", int'(auxOwn), 0);
    toIdle();
    curReq = "R3";
    for (int n = 0; n < 600; n++) begin
      irCode = IRW'($urandom_range(12, 31));
      tick(1'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule